// File: doc/BRIEF.md
# Direction-Free Wired-AND Bus Repeater

This block joins two segments of an open-collector (wired-AND) bus. Neither segment carries a direction pin. For each segment the block reads the line level and drives a pull-down enable. A released line floats high. The repeater therefore works out the direction of transfer from which segment first shows a low level that it did not cause itself.

When segment A goes low because an outside agent pulls it, the repeater pulls segment B low and holds it there while A stays low. Segment B behaves the same way towards A. The repeater's own pull-down makes the repeated segment read low, so that low is not taken as a new driver. Once the originating segment goes high again, the repeater releases. It then keeps both pull-downs off for a parameterised hold-off window so that the repeated line can rise, and only after that does it return to idle. Both line levels pass through a two-flop synchronizer before they reach the state logic.

Top module: `wand_repeater`

## Requirements
- R1: While reset is applied, and in idle after reset, both pull-down outputs are 0 (0 = released, 1 = pulling low).
- R2: A low on `a_level_i` seen in idle sets `b_pull_o` to 1 on the third rising clock edge after the input changes (two synchronizer stages plus one state register).
- R3: A low on `b_level_i` seen in idle sets `a_pull_o` to 1 with the same three-edge latency.
- R4: The repeated pull-down stays at 1 for as long as the originating side reads low. It drops to 0 on the third rising edge after the originating side returns high.
- R5: While A is the source, a low on side B has no effect on `a_pull_o`, whether the repeater itself or an outside agent causes that low. The mirror rule holds while B is the source.
- R6: If both sides go low in the same cycle while idle, A wins: `b_pull_o` becomes 1 and `a_pull_o` stays 0.
- R7: After a release, both pull-downs stay 0 for HOLDOFF_CYCLES+1 cycles. A low still present at the end of that window starts a new transfer on the following edge.
- R8: `a_pull_o` and `b_pull_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_level_i | input | 1 | Sensed level of segment A (0 = low) |
| b_level_i | input | 1 | Sensed level of segment B (0 = low) |
| a_pull_o | output | 1 | Pull-down enable for segment A |
| b_pull_o | output | 1 | Pull-down enable for segment B |

## Verification
Two functions can land in the same cycle. One is the start of a transfer from A and the other is the start of a transfer from B, when both segments are pulled low by outside agents on the same clock. The bench asserts both external pulls at one falling edge. It expects only `b_pull_o` to rise three edges later, and expects `a_pull_o` to stay 0 for as long as A holds. It then releases A while B is still held and checks that B takes over only after the full hold-off window. The line model in the bench wire-ANDs each external pull with the repeater's own pull, so the repeater's echo is present throughout these checks.

// File: rtl/wand_rptr_pkg.sv
package wand_rptr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_A_SRC   = 2'd1,
    ST_B_SRC   = 2'd2,
    ST_RECOVER = 2'd3
  } rptr_state_e;
endpackage

// File: rtl/wand_rptr_sync.sv
// Multi-stage level synchronizer; idle level of the bus is high.
module wand_rptr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wand_rptr_holdoff.sv
// Down-counter timing the quiet window after a release.
module wand_rptr_holdoff #(
  parameter int HOLDOFF_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (HOLDOFF_CYCLES > 1) ? $clog2(HOLDOFF_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(HOLDOFF_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i | (run_i & (cnt_q != '0));
    cnt_d  = load_i ? LOAD_VAL : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/wand_rptr_fsm.sv
// Direction-inference state machine.
module wand_rptr_fsm
  import wand_rptr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        a_low_i,
  input  logic        b_low_i,
  input  logic        hold_done_i,
  output rptr_state_e state_o,
  output logic        hold_load_o
);
  rptr_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    hold_load_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (a_low_i)      state_d = ST_A_SRC;   // A has priority
        else if (b_low_i) state_d = ST_B_SRC;
      end
      ST_A_SRC: begin
        if (!a_low_i) begin                      // B low ignored: own echo
          state_d     = ST_RECOVER;
          hold_load_o = 1'b1;
        end
      end
      ST_B_SRC: begin
        if (!b_low_i) begin
          state_d     = ST_RECOVER;
          hold_load_o = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (hold_done_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/wand_repeater.sv
module wand_repeater
  import wand_rptr_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int HOLDOFF_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_level_i,
  input  logic b_level_i,
  output logic a_pull_o,
  output logic b_pull_o
);
  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic [1:0]  lvl_sync;
  logic        a_lvl, b_lvl;
  logic        hold_load, hold_run, hold_done;
  rptr_state_e state;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wand_rptr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({b_level_i, a_level_i}),
    .q_o   (lvl_sync)
  );
  assign a_lvl = lvl_sync[0];
  assign b_lvl = lvl_sync[1];

  wand_rptr_fsm fsm_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .a_low_i     (~a_lvl),
    .b_low_i     (~b_lvl),
    .hold_done_i (hold_done),
    .state_o     (state),
    .hold_load_o (hold_load)
  );

  assign hold_run = (state == ST_RECOVER);

  wand_rptr_holdoff #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) hold_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (hold_load),
    .run_i  (hold_run),
    .done_o (hold_done)
  );

  assign b_pull_o = (state == ST_A_SRC);
  assign a_pull_o = (state == ST_B_SRC);
endmodule

// File: rtl/wand_repeater_chk.sv
module wand_repeater_chk
  import wand_rptr_pkg::*;
#(
  parameter int HOLDOFF_CYCLES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        a_lvl,
  input logic        b_lvl,
  input rptr_state_e state,
  input logic        a_pull_o,
  input logic        b_pull_o
);
  localparam int GW = $clog2(HOLDOFF_CYCLES + 2) + 1;
  localparam logic [GW-1:0] GAP_MAX = GW'(HOLDOFF_CYCLES + 1);

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (a_pull_o || b_pull_o) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else if (gap_q != GAP_MAX) begin
        gap_q  <= gap_q + 1'b1;
      end
    end
  end

  assert_pulls_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_pull_o && b_pull_o));

  assert_start_from_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !a_lvl) |=> b_pull_o);

  assert_start_from_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && a_lvl && !b_lvl) |=> a_pull_o);

  assert_hold_while_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (b_pull_o && !a_lvl) |=> b_pull_o);

  assert_echo_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    b_pull_o |=> !a_pull_o);

  assert_a_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !a_lvl && !b_lvl) |=> (b_pull_o && !a_pull_o));

  assert_quiet_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && ($rose(a_pull_o) || $rose(b_pull_o))) |-> (gap_q >= GAP_MAX));
endmodule

bind wand_repeater wand_repeater_chk #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .a_lvl    (a_lvl),
  .b_lvl    (b_lvl),
  .state    (state),
  .a_pull_o (a_pull_o),
  .b_pull_o (b_pull_o)
);

// File: tb/wand_repeater_tb_top.sv
`timescale 1ns/1ps
module wand_repeater_tb_top;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic ext_a, ext_b;          // external agents pulling low
  logic a_pull, b_pull;
  logic a_line, b_line;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;       // 50 MHz

  // wired-AND line model including the repeater's own pull-down
  assign a_line = ~(ext_a | a_pull);
  assign b_line = ~(ext_b | b_pull);

  wand_repeater #(.SYNC_STAGES(2), .HOLDOFF_CYCLES(HOLD)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_level_i (a_line),
    .b_level_i (b_line),
    .a_pull_o  (a_pull),
    .b_pull_o  (b_pull)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; ext_a = 1'b0; ext_b = 1'b0;
    step(2);
    check("R1", "a_pull in reset", a_pull, 1'b0);
    check("R1", "b_pull in reset", b_pull, 1'b0);
    rst_n = 1'b1;
    step(6);
    check("R1", "a_pull idle", a_pull, 1'b0);
    check("R1", "b_pull idle", b_pull, 1'b0);
  endtask

  task automatic t_a_to_b;
    ext_a = 1'b1;
    step(2);
    check("R2", "b_pull before latency", b_pull, 1'b0);
    step(1);
    check("R2", "b_pull after 3 edges", b_pull, 1'b1);
    check("R5", "a_pull with own echo on B", a_pull, 1'b0);
    step(10);
    check("R4", "b_pull held", b_pull, 1'b1);
    check("R5", "a_pull still off", a_pull, 1'b0);
    ext_a = 1'b0;
    step(2);
    check("R4", "b_pull before release latency", b_pull, 1'b1);
    step(1);
    check("R4", "b_pull released", b_pull, 1'b0);
    step(12);
    check("R7", "echo did not restart a_pull", a_pull, 1'b0);
    check("R7", "echo did not restart b_pull", b_pull, 1'b0);
  endtask

  task automatic t_b_to_a;
    ext_b = 1'b1;
    step(2);
    check("R3", "a_pull before latency", a_pull, 1'b0);
    step(1);
    check("R3", "a_pull after 3 edges", a_pull, 1'b1);
    check("R5", "b_pull with own echo on A", b_pull, 1'b0);
    step(7);
    check("R4", "a_pull held", a_pull, 1'b1);
    ext_b = 1'b0;
    step(3);
    check("R4", "a_pull released", a_pull, 1'b0);
    step(12);
    check("R7", "idle after B transfer", a_pull | b_pull, 1'b0);
  endtask

  task automatic t_both_same_cycle;
    ext_a = 1'b1; ext_b = 1'b1;
    step(3);
    check("R6", "b_pull wins", b_pull, 1'b1);
    check("R6", "a_pull loses", a_pull, 1'b0);
    step(6);
    check("R5", "external B low ignored", a_pull, 1'b0);
    check("R8", "not both pulling", a_pull & b_pull, 1'b0);
    ext_a = 1'b0;               // B still held externally
    step(3);
    check("R4", "b_pull released", b_pull, 1'b0);
    check("R7", "a_pull quiet at window start", a_pull, 1'b0);
    step(HOLD);
    check("R7", "a_pull quiet at window end", a_pull, 1'b0);
    step(1);
    check("R7", "B takes over after window", a_pull, 1'b1);
    check("R8", "b_pull off during B transfer", b_pull, 1'b0);
    ext_b = 1'b0;
    step(3);
    check("R4", "a_pull released", a_pull, 1'b0);
    step(HOLD + 4);
    check("R1", "back to idle", a_pull | b_pull, 1'b0);
  endtask

  initial begin
    t_reset();
    t_a_to_b();
    t_b_to_a();
    t_both_same_cycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule